// File: doc/BRIEF.md
# Oversampled SPI Register and Packet Buffer Slave

This block is a four-wire SPI slave that lets a host controller reach a radio's control space through one serial port. That space has three parts: a page of 64 directly addressed byte registers, a second page of indirectly addressed registers reached through an index and a data port, and a 128-byte packet memory. The transmit and receive frames share the packet memory, and the frame length byte sits at offset 0.

Every transaction begins by returning the current interrupt status byte on MISO. The host sees pending events while it is still sending the command byte, so it never spends a separate read on them. The command byte chooses direction and target. After the command, any number of data bytes may follow, and the relevant pointer advances after each one.

The SPI pins are not used as a clock. A system clock at least four times faster than SCLK samples them through a synchroniser and detects their edges. The SPI mode is 0: SCLK idles low, MOSI is sampled on the rising edge, and MISO changes after the falling edge.

Top module: `spirb_slave`

## Requirements
- R1: The first byte shifted out on MISO in every transaction, MSB first, equals `irq_status` as captured when select went active.
- R2: The first MOSI byte is a command. Bit 7 = 1 means read and 0 means write. Bit 6 = 1 means packet memory and 0 means register space. Bits 5:0 give the register address. During a read, data bytes return MSB first in the byte slots that follow the command.
- R3: A single-byte write to direct address A (other than 0x3E and 0x3F) stores the byte, and a later read of A returns it. Every register reads 0x00 after reset.
- R4: In register space, a burst advances the address by one after each data byte, modulo 64.
- R5: Address 0x3E holds a 6-bit index, which reads back zero-extended to 8 bits. Address 0x3F reads or writes the indirect register selected by the index. Each data byte at 0x3F advances the index by one, wrapping from 63 to 0, while the address stays at 0x3F.
- R6: A packet memory access always starts at offset 0, which holds the length byte, and bits 5:0 of the command are ignored. The memory holds 128 bytes.
- R7: In packet memory, a burst of reads or writes advances the offset after each byte and wraps from 127 to 0.
- R8: If select goes inactive before a byte is complete, the transaction is dropped. The partial byte is never written, and the next transaction starts fresh with the status byte.
- R9: MISO is driven 0 while select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from the host, idles low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| irq_status | input | 8 | Interrupt status byte returned first in each transaction |

## Verification
The bound checker checks four properties on every cycle:
- loading the status MSB onto MISO at the start of select;
- holding the bit counter clear and suppressing writes while deselected;
- advancing the packet offset by one on each buffer byte;
- advancing the index on each data-port byte.

Only the bench scenarios can show that data written over the serial line comes back unchanged, including values at the wrap points of both address spaces. The same applies to a burst crossing from the index register into the data port, and to an aborted byte leaving a register untouched.

// File: rtl/spirb_pkg.sv
package spirb_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = BYTE_W - 2;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA
   } spirb_state_e;

   typedef struct packed {
      logic              rd;
      logic              buf_sel;
      logic [ADDR_W-1:0] addr;
   } spirb_cmd_t;
endpackage

// File: rtl/spirb_sync.sv
module spirb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic csn_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_act,
   output logic cs_start,
   output logic mosi_s
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spirb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sclk_q, csn_q, mosi_q;
   logic              sclk_prev, act_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= '0;
         csn_q     <= '1;
         mosi_q    <= '0;
         sclk_prev <= 1'b0;
         act_prev  <= 1'b0;
      end else begin
         sclk_q    <= {sclk_q[STAGES-2:0], sclk_i};
         csn_q     <= {csn_q[STAGES-2:0], csn_i};
         mosi_q    <= {mosi_q[STAGES-2:0], mosi_i};
         sclk_prev <= sclk_q[STAGES-1];
         act_prev  <= ~csn_q[STAGES-1];
      end
   end

   assign cs_act    = ~csn_q[STAGES-1];
   assign cs_start  = cs_act & ~act_prev;
   assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev;
   assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev;
   assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/spirb_shifter.sv
module spirb_shifter
   import spirb_pkg::*;
#(
   parameter int CNT_W = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_start,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi_s,
   input  logic [BYTE_W-1:0] status_byte,
   input  logic [BYTE_W-1:0] next_tx,
   output logic              miso_bit,
   output logic              byte_done,
   output logic [BYTE_W-1:0] rx_byte,
   output logic [CNT_W-1:0]  bit_cnt
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   generate
      if ((1 << CNT_W) < BYTE_W) begin : g_bad_cnt
         $error("spirb_shifter: CNT_W too small for BYTE_W");
      end
   endgenerate

   logic [BYTE_W-1:0] rx_sr, tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
         end else if (cs_start) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= status_byte;
         end else begin
            if (sclk_rise) begin
               rx_sr <= {rx_sr[BYTE_W-2:0], mosi_s};
               if (bit_cnt == LAST_BIT) begin
                  bit_cnt   <= '0;
                  byte_done <= 1'b1;
                  rx_byte   <= {rx_sr[BYTE_W-2:0], mosi_s};
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (sclk_fall) begin
               if (bit_cnt == '0) tx_sr <= next_tx;
               else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso_bit = tx_sr[BYTE_W-1];
endmodule

// File: rtl/spirb_pktram.sv
module spirb_pktram #(
   parameter int AW = 7,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("spirb_pktram: AW out of range");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/spirb_slave.sv
module spirb_slave
   import spirb_pkg::*;
#(
   parameter int              IND_AW      = 6,
   parameter int              BUF_AW      = 7,
   parameter int              SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] IDX_ADDR  = 6'h3E,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 6'h3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_csn,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic [BYTE_W-1:0] irq_status
);
   localparam int DIR_DEPTH = 1 << ADDR_W;
   localparam int IND_DEPTH = 1 << IND_AW;
   localparam int CNT_W     = $clog2(BYTE_W);

   generate
      if (IND_AW < 1 || IND_AW > BYTE_W) begin : g_bad_ind
         $error("spirb_slave: IND_AW must be 1..BYTE_W");
      end
      if (IDX_ADDR == DATA_ADDR) begin : g_bad_map
         $error("spirb_slave: index and data addresses must differ");
      end
   endgenerate

   logic              sclk_rise, sclk_fall, cs_act, cs_start, mosi_s;
   logic              byte_done;
   logic [BYTE_W-1:0] rx_byte, next_tx, rd_data, ram_rdata;
   logic [CNT_W-1:0]  bit_cnt;

   spirb_state_e      state;
   logic              cmd_rd, cmd_buf;
   logic [ADDR_W-1:0] reg_ptr;
   logic [BUF_AW-1:0] buf_ptr;
   logic [IND_AW-1:0] ind_idx;
   logic [BYTE_W-1:0] dir_mem [DIR_DEPTH];
   logic [BYTE_W-1:0] ind_mem [IND_DEPTH];
   spirb_cmd_t        cmd_in;
   logic              in_data, wr_en, buf_we;

   spirb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_i   (spi_sclk),
      .csn_i    (spi_csn),
      .mosi_i   (spi_mosi),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .cs_act   (cs_act),
      .cs_start (cs_start),
      .mosi_s   (mosi_s)
   );

   spirb_shifter #(.CNT_W(CNT_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .cs_start   (cs_start),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .mosi_s     (mosi_s),
      .status_byte(irq_status),
      .next_tx    (next_tx),
      .miso_bit   (spi_miso),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .bit_cnt    (bit_cnt)
   );

   spirb_pktram #(.AW(BUF_AW), .DW(BYTE_W)) u_ram (
      .clk  (clk),
      .we   (buf_we),
      .waddr(buf_ptr),
      .wdata(rx_byte),
      .raddr(buf_ptr),
      .rdata(ram_rdata)
   );

   assign cmd_in  = spirb_cmd_t'(rx_byte);
   assign in_data = (state == ST_DATA);
   assign wr_en   = byte_done & in_data & ~cmd_rd;
   assign buf_we  = wr_en & cmd_buf;

   always_comb begin
      if (cmd_buf)                   rd_data = ram_rdata;
      else if (reg_ptr == IDX_ADDR)  rd_data = BYTE_W'(ind_idx);
      else if (reg_ptr == DATA_ADDR) rd_data = ind_mem[ind_idx];
      else                           rd_data = dir_mem[reg_ptr];
      next_tx = (in_data && cmd_rd) ? rd_data : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cmd_rd  <= 1'b0;
         cmd_buf <= 1'b0;
         reg_ptr <= '0;
         buf_ptr <= '0;
         ind_idx <= '0;
         for (int i = 0; i < DIR_DEPTH; i++) dir_mem[i] <= '0;
         for (int i = 0; i < IND_DEPTH; i++) ind_mem[i] <= '0;
      end else if (!cs_act) begin
         state <= ST_IDLE;
      end else if (cs_start) begin
         state <= ST_CMD;
      end else if (byte_done) begin
         if (state == ST_CMD) begin
            cmd_rd  <= cmd_in.rd;
            cmd_buf <= cmd_in.buf_sel;
            reg_ptr <= cmd_in.addr;
            buf_ptr <= '0;
            state   <= ST_DATA;
         end else if (state == ST_DATA) begin
            if (!cmd_rd && !cmd_buf) begin
               if (reg_ptr == IDX_ADDR)       ind_idx <= rx_byte[IND_AW-1:0];
               else if (reg_ptr == DATA_ADDR) ind_mem[ind_idx] <= rx_byte;
               else                           dir_mem[reg_ptr] <= rx_byte;
            end
            if (cmd_buf)                   buf_ptr <= buf_ptr + 1'b1;
            else if (reg_ptr == DATA_ADDR) ind_idx <= ind_idx + 1'b1;
            else                           reg_ptr <= reg_ptr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spirb_slave_chk.sv
module spirb_slave_chk
   import spirb_pkg::*;
#(
   parameter int                IND_AW    = 6,
   parameter int                BUF_AW    = 7,
   parameter int                CNT_W     = 3,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 6'h3F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              spi_miso,
   input logic [BYTE_W-1:0] irq_status,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              byte_done,
   input logic              in_data,
   input logic              cmd_buf,
   input logic              wr_en,
   input logic [ADDR_W-1:0] reg_ptr,
   input logic [BUF_AW-1:0] buf_ptr,
   input logic [IND_AW-1:0] ind_idx
);
   // R1
   status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_act) |=> spi_miso == $past(irq_status[BYTE_W-1]));

   // R8
   idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> bit_cnt == '0);

   // R8
   no_idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cs_act) |-> !wr_en);

   // R7
   buf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && in_data && cmd_buf) |=> buf_ptr == $past(buf_ptr) + 1'b1);

   // R5
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && in_data && !cmd_buf && reg_ptr == DATA_ADDR)
      |=> ind_idx == $past(ind_idx) + 1'b1);
endmodule

bind spirb_slave spirb_slave_chk #(
   .IND_AW   (IND_AW),
   .BUF_AW   (BUF_AW),
   .CNT_W    (CNT_W),
   .DATA_ADDR(DATA_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_act    (cs_act),
   .spi_miso  (spi_miso),
   .irq_status(irq_status),
   .bit_cnt   (bit_cnt),
   .byte_done (byte_done),
   .in_data   (in_data),
   .cmd_buf   (cmd_buf),
   .wr_en     (wr_en),
   .reg_ptr   (reg_ptr),
   .buf_ptr   (buf_ptr),
   .ind_idx   (ind_idx)
);

// File: tb/spirb_slave_bench.sv
module spirb_slave_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_CLKS  = 6;
   localparam int NVEC       = 10;

   // {command, write data, expected read data}
   localparam logic [23:0] VEC [NVEC] = '{
      {8'h05, 8'h3C, 8'h00},
      {8'h10, 8'hC3, 8'h00},
      {8'h85, 8'h00, 8'h3C},
      {8'h90, 8'h00, 8'hC3},
      {8'h3E, 8'h07, 8'h00},
      {8'h3F, 8'h99, 8'h00},
      {8'hBE, 8'h00, 8'h08},
      {8'h3E, 8'h07, 8'h00},
      {8'hBF, 8'h00, 8'h99},
      {8'h80, 8'h00, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_sclk = 1'b0;
   logic       spi_csn = 1'b1;
   logic       spi_mosi = 1'b0;
   logic       spi_miso;
   logic [7:0] irq_status = 8'h00;

   logic [7:0] tx_q [140];
   logic [7:0] rx_q [140];
   int         checks = 0;
   int         errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spirb_slave u_spirb_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sclk  (spi_sclk),
      .spi_csn   (spi_csn),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso),
      .irq_status(irq_status)
   );

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 3 + 1) & 255);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic xfer(input int nbytes, input int tail_bits);
      int total;
      total = nbytes + ((tail_bits > 0) ? 1 : 0);
      @(negedge clk);
      spi_csn = 1'b0;
      repeat (8) @(negedge clk);
      for (int b = 0; b < total; b++) begin
         int nb;
         nb = (b < nbytes) ? 8 : tail_bits;
         rx_q[b] = 8'h00;
         for (int i = 0; i < nb; i++) begin
            spi_mosi = tx_q[b][7-i];
            repeat (HALF_CLKS) @(negedge clk);
            rx_q[b][7-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF_CLKS) @(negedge clk);
            spi_sclk = 1'b0;
         end
      end
      repeat (HALF_CLKS) @(negedge clk);
      spi_csn = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9: idle line after reset
      chk("R9 idle miso", {7'd0, spi_miso}, 8'h00);

      // R3 reset value, R1 status byte
      irq_status = 8'h5A;
      tx_q[0] = 8'hA0; tx_q[1] = 8'h00;
      xfer(2, 0);
      chk("R1 status after reset", rx_q[0], 8'h5A);
      chk("R3 reset value", rx_q[1], 8'h00);

      // R2 R3 R5: table walk
      for (int v = 0; v < NVEC; v++) begin
         irq_status = 8'((v * 37 + 3) & 255);
         tx_q[0] = VEC[v][23:16];
         tx_q[1] = VEC[v][15:8];
         xfer(2, 0);
         chk("R1 status", rx_q[0], irq_status);
         if (VEC[v][23]) chk("R2/R3/R5 read", rx_q[1], VEC[v][7:0]);
      end

      // R4: direct burst
      tx_q[0] = 8'h21; tx_q[1] = 8'hD1; tx_q[2] = 8'hD2; tx_q[3] = 8'hD3;
      xfer(4, 0);
      tx_q[0] = 8'hA1;
      xfer(4, 0);
      chk("R4 burst 0", rx_q[1], 8'hD1);
      chk("R4 burst 1", rx_q[2], 8'hD2);
      chk("R4 burst 2", rx_q[3], 8'hD3);

      // R4 R5: burst from 0x3D into index, then data port
      tx_q[0] = 8'h3D; tx_q[1] = 8'h44; tx_q[2] = 8'h05; tx_q[3] = 8'h77; tx_q[4] = 8'h78;
      xfer(5, 0);
      tx_q[0] = 8'hBD;
      xfer(5, 0);
      chk("R4 reg 3D", rx_q[1], 8'h44);
      chk("R5 index after burst", rx_q[2], 8'h07);
      chk("R5 data idx7", rx_q[3], 8'h99);
      chk("R5 data idx8", rx_q[4], 8'h00);
      tx_q[0] = 8'h3E; tx_q[1] = 8'h05;
      xfer(2, 0);
      tx_q[0] = 8'hBF;
      xfer(3, 0);
      chk("R5 data idx5", rx_q[1], 8'h77);
      chk("R5 data idx6", rx_q[2], 8'h78);

      // R5: index wrap 63 -> 0
      tx_q[0] = 8'h3E; tx_q[1] = 8'h3F; tx_q[2] = 8'hA1; tx_q[3] = 8'hA2;
      xfer(4, 0);
      tx_q[0] = 8'hBE;
      xfer(2, 0);
      chk("R5 index wrapped", rx_q[1], 8'h01);
      tx_q[0] = 8'h3E; tx_q[1] = 8'h00;
      xfer(2, 0);
      tx_q[0] = 8'hBF;
      xfer(2, 0);
      chk("R5 idx0 after wrap", rx_q[1], 8'hA2);

      // R6 R7: buffer write burst of 129 bytes wraps onto offset 0
      tx_q[0] = 8'h5F;
      for (int k = 0; k < 129; k++) tx_q[k+1] = pat(k);
      xfer(130, 0);
      tx_q[0] = 8'hC9;
      for (int k = 1; k < 131; k++) tx_q[k] = 8'h00;
      xfer(131, 0);
      chk("R6 length byte at 0", rx_q[1], pat(128));
      for (int k = 1; k < 128; k++) chk("R6/R7 buffer data", rx_q[k+1], pat(k));
      chk("R7 read wrap to 0", rx_q[129], pat(128));
      chk("R7 read wrap to 1", rx_q[130], pat(1));

      // R8: aborted data byte leaves register unchanged
      tx_q[0] = 8'h30; tx_q[1] = 8'h11;
      xfer(2, 0);
      tx_q[0] = 8'h30; tx_q[1] = 8'hFF;
      xfer(1, 4);
      chk("R9 miso after abort", {7'd0, spi_miso}, 8'h00);
      irq_status = 8'hC6;
      tx_q[0] = 8'hB0;
      xfer(2, 0);
      chk("R8 status after abort", rx_q[0], 8'hC6);
      chk("R8 partial byte not written", rx_q[1], 8'h11);

      // R8: aborted command byte
      tx_q[0] = 8'h30;
      xfer(0, 5);
      irq_status = 8'h3B;
      tx_q[0] = 8'hB0;
      xfer(2, 0);
      chk("R8 status after cmd abort", rx_q[0], 8'h3B);
      chk("R8 read after cmd abort", rx_q[1], 8'h11);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule